// File: doc/BRIEF.md
# Write-Protection Command Sequencer for a Byte-Wide EEPROM

This block sits between the host write path and a byte-wide nonvolatile array and decides, write by write, whether a host byte reaches the array. Two protection levels are stacked. The first is a global software write-protect flag. While it is set, the host must send a three-byte unlock prefix before it writes array bytes. The second is an eight-bit lock mask. Each bit freezes one 1 KB region, and a locked region rejects array writes even straight after a valid unlock prefix.

Multi-byte command sequences set the flag, clear it, or open the lock mask for loading. Command bytes never reach the array. Successive bytes of a sequence must arrive within a byte-load window of `LOAD_WIN` idle clock cycles, or the sequence is abandoned. The flag and the mask model nonvolatile bits. Only the power-on reset `por_n` clears them. The ordinary reset `rst_n` returns the sequencer and the outputs to idle and leaves both untouched.

Host writes enter on a valid/ready stream. Approved writes leave on a second valid/ready stream towards the array programming logic. The block holds one pending commit. `wr_ready` is high whenever that slot is empty or is being drained in the same cycle (`commit_ready` high). While `commit_valid` is high and `commit_ready` is low, `commit_addr` and `commit_data` hold steady and no new host write is taken. The pulses `cmd_done` and `wr_reject` are not back-pressured.

Top module: `eeprom_guard`

## Requirements
- R1: After `por_n`, the protect flag and lock mask are zero, every output pulse is low, `wr_ready` is high, and an ordinary write is committed.
- R2: Data 0xAA at address 0x555, then 0x55 at 0xAAA, then 0xA0 at 0x555 are consumed. Each of these writes gives one `cmd_done` pulse. The last one sets `prot_en`. Later ordinary writes are committed until the sequence state is left.
- R3: While `prot_en` is 1, an ordinary write that does not follow an unlock prefix gives a `wr_reject` pulse and no commit.
- R4: The five-byte sequence AA@555, 55@AAA, A0@555, AA@555, 80@AAA clears `prot_en`. After it, ordinary writes to unlocked blocks are committed.
- R5: The five-byte sequence AA@555, 55@AAA, A0@555, AA@555, C0@AAA makes the next write, to any address, load its data byte into `lock_mask`. That write is consumed and not committed.
- R6: Bit i of `lock_mask` (1 = locked) covers the addresses whose bits [12:10] equal i. A write to a locked block is rejected, even when it follows an unlock prefix.
- R7: Only address bits [11:0] are compared with 0x555 and 0xAAA. Bit 12 has no effect on whether a sequence step matches.
- R8: If `LOAD_WIN` or more idle cycles pass between two writes, a sequence in progress is dropped, including the unlocked page state. A gap shorter than `LOAD_WIN` keeps it.
- R9: A write whose address or data does not match the expected next step returns the sequencer to idle. It is then judged as an ordinary write: committed if protection is off and its block is unlocked, rejected otherwise.
- R10: `rst_n` leaves `prot_en` and `lock_mask` unchanged and resets the sequence state. Only `por_n` clears them.
- R11: While `commit_valid` is 1 and `commit_ready` is 0, the commit address and data stay stable and `wr_ready` is 0.
- R12: Each accepted host write gives exactly one of commit, `cmd_done` or `wr_reject` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset of sequencer and outputs, active low |
| por_n | input | 1 | Synchronous power-on reset, also clears the flag and the mask, active low |
| wr_valid | input | 1 | Host write present |
| wr_ready | output | 1 | Host write can be taken |
| wr_addr | input | 13 | Host write address |
| wr_data | input | 8 | Host write data |
| commit_valid | output | 1 | Approved array write pending |
| commit_ready | input | 1 | Array side takes the pending write |
| commit_addr | output | 13 | Address of approved write |
| commit_data | output | 8 | Data of approved write |
| cmd_done | output | 1 | One-cycle pulse: previous write was a command byte |
| wr_reject | output | 1 | One-cycle pulse: previous write was dropped |
| prot_en | output | 1 | Software write-protect flag |
| lock_mask | output | 8 | Block lock mask, 1 = locked |

## Verification
The directed part walks each sequence in full. It also breaks them at every step with a wrong address or wrong data, so an abort can be told apart from a sequence that wrongly continues. It uses key addresses with bit 12 set and clear, and it places writes on both sides of locked and unlocked block boundaries, so the mask decode can be separated from the protect flag. Idle gaps just inside and beyond the byte-load window show whether the timer aborts at the right point. The random part draws addresses and data with a bias towards key values, so that partial sequences, nested restarts and stray command bytes occur often, and a bench model predicts commit, consume or reject for each one.

// File: rtl/eepg_pkg.sv
package eepg_pkg;
  localparam int ADDR_W = 13;
  localparam int DATA_W = 8;
  localparam int KEY_W  = 12;
  localparam int NBLK   = DATA_W;
  localparam int BLK_W  = $clog2(NBLK);

  localparam logic [KEY_W-1:0] KEY_LO = 12'h555;
  localparam logic [KEY_W-1:0] KEY_HI = 12'hAAA;

  localparam logic [DATA_W-1:0] CODE_PRE  = 8'hAA;
  localparam logic [DATA_W-1:0] CODE_SEC  = 8'h55;
  localparam logic [DATA_W-1:0] CODE_OPEN = 8'hA0;
  localparam logic [DATA_W-1:0] CODE_OFF  = 8'h80;
  localparam logic [DATA_W-1:0] CODE_LOCK = 8'hC0;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_K1, SQ_K2, SQ_OPEN, SQ_K4, SQ_MASK
  } seq_t;
endpackage

// File: rtl/eepg_seq.sv
module eepg_seq
  import eepg_pkg::*;
#(
  parameter int LOAD_WIN = 12500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              fire,
  input  logic [KEY_W-1:0]  key_addr,
  input  logic [DATA_W-1:0] data,
  output logic              step_o,
  output logic              arm_o,
  output logic              disarm_o,
  output logic              mask_ld_o,
  output logic              array_o,
  output logic              open_o
);
  localparam int CNT_W = $clog2(LOAD_WIN + 1);

  seq_t             state, nxt;
  logic [CNT_W-1:0] cnt;
  logic             lo_hit, hi_hit;
  logic             step, arm, disarm, mask_ld, array_w;

  assign lo_hit = (key_addr == KEY_LO);
  assign hi_hit = (key_addr == KEY_HI);

  always_comb begin
    nxt     = state;
    step    = 1'b0;
    arm     = 1'b0;
    disarm  = 1'b0;
    mask_ld = 1'b0;
    array_w = 1'b0;
    open_o  = 1'b0;
    case (state)
      SQ_IDLE:
        if (lo_hit && data == CODE_PRE) begin nxt = SQ_K1; step = 1'b1; end
        else array_w = 1'b1;
      SQ_K1:
        if (hi_hit && data == CODE_SEC) begin nxt = SQ_K2; step = 1'b1; end
        else begin nxt = SQ_IDLE; array_w = 1'b1; end
      SQ_K2:
        if (lo_hit && data == CODE_OPEN) begin
          nxt = SQ_OPEN; step = 1'b1; arm = 1'b1;
        end else begin nxt = SQ_IDLE; array_w = 1'b1; end
      SQ_OPEN:
        if (lo_hit && data == CODE_PRE) begin nxt = SQ_K4; step = 1'b1; end
        else begin array_w = 1'b1; open_o = 1'b1; end
      SQ_K4:
        if (hi_hit && data == CODE_OFF) begin
          nxt = SQ_IDLE; step = 1'b1; disarm = 1'b1;
        end else if (hi_hit && data == CODE_LOCK) begin
          nxt = SQ_MASK; step = 1'b1;
        end else begin nxt = SQ_IDLE; array_w = 1'b1; end
      SQ_MASK: begin nxt = SQ_IDLE; step = 1'b1; mask_ld = 1'b1; end
      default: nxt = SQ_IDLE;
    endcase
  end

  assign step_o    = fire && step;
  assign arm_o     = fire && arm;
  assign disarm_o  = fire && disarm;
  assign mask_ld_o = fire && mask_ld;
  assign array_o   = fire && array_w;

  // byte-load window: idle cycles since the last accepted write
  always_ff @(posedge clk) begin
    if (!rst_n || !por_n) begin
      state <= SQ_IDLE;
      cnt   <= '0;
    end else if (fire) begin
      state <= nxt;
      cnt   <= '0;
    end else if (state != SQ_IDLE) begin
      if (cnt == CNT_W'(LOAD_WIN - 1)) begin
        state <= SQ_IDLE;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_win_bound_R8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (state != SQ_IDLE) |-> (cnt <= CNT_W'(LOAD_WIN - 1)));

  assert_arm_open_R2: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    arm_o |=> (state == SQ_OPEN));

  assert_step_excl_R12: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    fire |-> (step_o != array_o));
endmodule

// File: rtl/eepg_nvregs.sv
module eepg_nvregs
  import eepg_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              arm,
  input  logic              disarm,
  input  logic              mask_ld,
  input  logic [DATA_W-1:0] din,
  output logic              prot_en,
  output logic [NBLK-1:0]   lock_mask
);
  always_ff @(posedge clk) begin
    if (!por_n) begin
      prot_en   <= 1'b0;
      lock_mask <= '0;
    end else begin
      if (arm)         prot_en <= 1'b1;
      else if (disarm) prot_en <= 1'b0;
      if (mask_ld)     lock_mask <= din;
    end
  end

  assert_mask_keep_R10: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(lock_mask) |-> $past(mask_ld));

  assert_disarm_R4: assert property (@(posedge clk) disable iff (!por_n)
    disarm |=> !prot_en);
endmodule

// File: rtl/eepg_lockmap.sv
module eepg_lockmap
  import eepg_pkg::*;
(
  input  logic [NBLK-1:0]  lock_mask,
  input  logic [BLK_W-1:0] blk,
  output logic             locked
);
  logic [NBLK-1:0] hit;

  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    assign hit[i] = lock_mask[i] && (blk == BLK_W'(i));
  end

  assign locked = |hit;
endmodule

// File: rtl/eeprom_guard.sv
module eeprom_guard
  import eepg_pkg::*;
#(
  parameter int LOAD_WIN = 12500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              commit_valid,
  input  logic              commit_ready,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data,
  output logic              cmd_done,
  output logic              wr_reject,
  output logic              prot_en,
  output logic [NBLK-1:0]   lock_mask
);
  logic fire, step, arm, disarm, mask_ld, array_w, open_ctx, locked, ok;

  assign wr_ready = !commit_valid || commit_ready;
  assign fire     = wr_valid && wr_ready;

  eepg_seq #(.LOAD_WIN(LOAD_WIN)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .por_n     (por_n),
    .fire      (fire),
    .key_addr  (wr_addr[KEY_W-1:0]),
    .data      (wr_data),
    .step_o    (step),
    .arm_o     (arm),
    .disarm_o  (disarm),
    .mask_ld_o (mask_ld),
    .array_o   (array_w),
    .open_o    (open_ctx)
  );

  eepg_nvregs u_nv (
    .clk       (clk),
    .por_n     (por_n),
    .arm       (arm),
    .disarm    (disarm),
    .mask_ld   (mask_ld),
    .din       (wr_data),
    .prot_en   (prot_en),
    .lock_mask (lock_mask)
  );

  eepg_lockmap u_map (
    .lock_mask (lock_mask),
    .blk       (wr_addr[ADDR_W-1 -: BLK_W]),
    .locked    (locked)
  );

  assign ok = array_w && !locked && (open_ctx || !prot_en);

  always_ff @(posedge clk) begin
    if (!rst_n || !por_n) begin
      commit_valid <= 1'b0;
      commit_addr  <= '0;
      commit_data  <= '0;
      cmd_done     <= 1'b0;
      wr_reject    <= 1'b0;
    end else begin
      cmd_done  <= step;
      wr_reject <= array_w && !ok;
      if (fire) begin
        commit_valid <= ok;
        if (ok) begin
          commit_addr <= wr_addr;
          commit_data <= wr_data;
        end
      end else if (commit_ready) begin
        commit_valid <= 1'b0;
      end
    end
  end

  assert_one_out_R12: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    fire |=> ($countones({commit_valid, cmd_done, wr_reject}) == 1));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (commit_valid && !commit_ready) |=>
      (commit_valid && $stable(commit_addr) && $stable(commit_data)));

  assert_locked_drop_R6: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (fire && locked) |=> !commit_valid);

  assert_prot_drop_R3: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (array_w && prot_en && !open_ctx) |=> !commit_valid);
endmodule

// File: tb/eeprom_guard_tb.sv
`timescale 1ns/1ps
module eeprom_guard_tb;
  localparam int WIN = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, por_n = 1'b0;
  logic        wr_valid = 1'b0, commit_ready = 1'b1;
  logic [12:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        wr_ready, commit_valid, cmd_done, wr_reject, prot_en;
  logic [12:0] commit_addr;
  logic [7:0]  commit_data, lock_mask;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference model state
  int       ms = 0;
  bit       mp = 1'b0;
  bit [7:0] mm = '0;
  int       gap = 0;

  always #4 clk = ~clk;

  eeprom_guard #(.LOAD_WIN(WIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit_valid(commit_valid), .commit_ready(commit_ready),
    .commit_addr(commit_addr), .commit_data(commit_data),
    .cmd_done(cmd_done), .wr_reject(wr_reject),
    .prot_en(prot_en), .lock_mask(lock_mask)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // outcome predicted from the requirements: 0 commit, 1 consumed, 2 rejected
  function automatic int predict(input bit [12:0] a, input bit [7:0] d);
    bit lo, hi, arr, open_c;
    int cls;
    if (ms != 0 && gap >= WIN) ms = 0;     // R8
    gap = 0;
    lo = (a[11:0] == 12'h555);            // R7
    hi = (a[11:0] == 12'hAAA);
    arr = 1'b0; open_c = 1'b0; cls = 1;
    case (ms)
      0: if (lo && d == 8'hAA) ms = 1; else arr = 1'b1;
      1: if (hi && d == 8'h55) ms = 2; else begin ms = 0; arr = 1'b1; end
      2: if (lo && d == 8'hA0) begin ms = 3; mp = 1'b1; end
         else begin ms = 0; arr = 1'b1; end
      3: if (lo && d == 8'hAA) ms = 4; else begin arr = 1'b1; open_c = 1'b1; end
      4: if (hi && d == 8'h80) begin ms = 0; mp = 1'b0; end
         else if (hi && d == 8'hC0) ms = 5;
         else begin ms = 0; arr = 1'b1; end
      default: begin mm = d; ms = 0; end
    endcase
    if (arr) cls = (!mm[a[12:10]] && (open_c || !mp)) ? 0 : 2;
    return cls;
  endfunction

  task automatic wr(input logic [12:0] a, input logic [7:0] d, input string req);
    int cls;
    logic [63:0] act, exp;
    wr_addr = a; wr_data = d; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    cls = predict(a, d);
    act = {29'd0, commit_valid, cmd_done, wr_reject, prot_en, lock_mask, commit_addr, commit_data};
    exp = {29'd0, cls == 0, cls == 1, cls == 2, mp, mm,
           (cls == 0) ? a : commit_addr, (cls == 0) ? d : commit_data};
    chk(act == exp, req, act, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    gap += n;
  endtask

  task automatic seq3(input logic [12:0] hi_bit, input string req);
    wr(13'h0555 | hi_bit, 8'hAA, req);
    wr(13'h0AAA | hi_bit, 8'h55, req);
    wr(13'h0555 | hi_bit, 8'hA0, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({commit_valid, cmd_done, wr_reject, prot_en, lock_mask} == 12'd0 && wr_ready,
        "R1", {commit_valid, cmd_done, wr_reject, prot_en, lock_mask, wr_ready}, 64'h1);
    wr(13'h0123, 8'h11, "R1");

    // R2 unlock and page writes, R8 window abort, R3 protected reject
    seq3(13'h0, "R2");
    wr(13'h0456, 8'h22, "R2");
    idle(3);
    wr(13'h0457, 8'h23, "R2");
    idle(WIN + 2);
    wr(13'h0100, 8'h33, "R3");
    wr(13'h0AAA, 8'h55, "R3");

    // R7 bit 12 ignored in keys
    seq3(13'h1000, "R7");
    wr(13'h1234, 8'h44, "R7");
    wr(13'h1555, 8'hAA, "R7");
    wr(13'h0AAA, 8'hC0, "R7");
    wr(13'h0777, 8'h05, "R5");   // R5 mask load at any address
    idle(WIN);

    // R6 lock decode after unlock
    seq3(13'h0, "R6");
    wr(13'h0010, 8'h01, "R6");
    wr(13'h0410, 8'h02, "R6");
    wr(13'h0810, 8'h03, "R6");
    wr(13'h1C00, 8'h04, "R6");
    wr(13'h03FF, 8'h05, "R6");
    wr(13'h0400, 8'h06, "R6");
    idle(WIN);

    // R9 mismatches with protection on
    wr(13'h0555, 8'hAA, "R9");
    wr(13'h0400, 8'h77, "R9");
    wr(13'h0555, 8'hAA, "R9");
    wr(13'h0AAA, 8'h54, "R9");

    // R4 disable sequence
    seq3(13'h0, "R4");
    wr(13'h0555, 8'hAA, "R4");
    wr(13'h0AAA, 8'h80, "R4");
    wr(13'h0400, 8'h07, "R4");
    wr(13'h0000, 8'h08, "R6");

    // R9 mismatch with protection off
    wr(13'h0555, 8'hAA, "R9");
    wr(13'h0AAA, 8'h55, "R9");
    wr(13'h0C00, 8'h12, "R9");
    wr(13'h0AAA, 8'h55, "R9");
    wr(13'h0555, 8'hAA, "R9");
    wr(13'h0555, 8'hAA, "R9");
    idle(WIN);

    // R8 gaps just inside the window keep the sequence
    wr(13'h0555, 8'hAA, "R8");
    idle(WIN - 1);
    wr(13'h0AAA, 8'h55, "R8");
    idle(WIN - 1);
    wr(13'h0555, 8'hA0, "R8");
    idle(WIN - 1);
    wr(13'h0401, 8'h09, "R8");
    wr(13'h0555, 8'hAA, "R8");
    idle(WIN);
    wr(13'h0AAA, 8'h80, "R8");

    // R11 back-pressure on the commit side
    seq3(13'h0, "R11");
    commit_ready = 1'b0;
    wr(13'h0402, 8'h5A, "R11");
    idle(2);
    chk(commit_valid && !wr_ready && commit_addr == 13'h0402 && commit_data == 8'h5A, "R11",
        {commit_valid, wr_ready, commit_addr, commit_data}, {2'b10, 13'h0402, 8'h5A});
    commit_ready = 1'b1;
    idle(1);
    chk(!commit_valid && wr_ready, "R11", {commit_valid, wr_ready}, 2'b01);

    // R10 rst_n keeps nonvolatile state, por_n clears it
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    ms = 0; gap = 0;
    idle(1);
    chk(prot_en == mp && lock_mask == mm && mp, "R10", {prot_en, lock_mask}, {mp, mm});
    wr(13'h0402, 8'h5B, "R10");
    por_n = 1'b0;
    idle(2);
    por_n = 1'b1;
    ms = 0; gap = 0; mp = 1'b0; mm = '0;
    idle(1);
    chk(!prot_en && lock_mask == 8'h00, "R10", {prot_en, lock_mask}, 64'h0);
    wr(13'h0000, 8'h66, "R10");

    // R12 random mix, biased towards key addresses and codes
    void'($urandom(32'h5eed));
    for (int i = 0; i < 800; i++) begin
      logic [12:0] a;
      logic [7:0]  d;
      int sel;
      sel = $urandom_range(0, 9);
      a = (sel < 3) ? 13'h0555 : (sel < 6) ? 13'h0AAA : 13'($urandom);
      if (sel < 6 && $urandom_range(0, 3) == 0) a[12] = 1'b1;
      sel = $urandom_range(0, 9);
      case (sel)
        0, 1: d = 8'hAA;
        2:    d = 8'h55;
        3:    d = 8'hA0;
        4:    d = 8'h80;
        5:    d = 8'hC0;
        default: d = 8'($urandom);
      endcase
      wr(a, d, "R12");
      if ($urandom_range(0, 15) == 0) idle(WIN + 5);
      else idle($urandom_range(0, 3));
    end
    finish_run();
  end
endmodule